// File: doc/BRIEF.md
# Dual-Channel Down-Counting Timer

This block is a memory-mapped timer with `NCH` identical channels behind a simple 32-bit register port that uses one-cycle write and read strobes. Each channel holds a down-counter, an interval word, a 3-bit power-of-two prescaler, an enable bit, a one-shot select bit and a self-clearing reload request. When the counter is at zero on a prescaled tick, the channel raises its pending flag. In periodic mode it then reloads the interval and keeps counting. In one-shot mode it parks at zero. A shared enable mask gates the pending flags onto a single interrupt line.

Channel 0 is meant to produce event interrupts. Channel 1 is meant to run freely as a time base, and software inverts its count to obtain a rising value. Each channel is sequenced by a four-state machine:

- `CH_IDLE`: frozen.
- `CH_RUN`: counting.
- `CH_DRAIN`: enable has dropped, but counting continues for `STOP_LAT` more timer clocks.
- `CH_DONE`: a one-shot channel that has expired.

Its transitions are:

- IDLE→RUN when enable is set.
- RUN→DRAIN when enable is cleared.
- RUN→DONE on a one-shot expiry.
- DRAIN→IDLE when the drain count is reached, or on a one-shot expiry.
- DONE→IDLE when enable is cleared.
- DONE→RUN on a reload request while enabled.

Top module: `tmr_dual_down`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: In periodic mode, with interval I and prescale field p, the pending flag sets 1+(I+1)·2^p clocks after the control write that sets enable and reload. After that it sets again every (I+1)·2^p clocks.
- R3: In one-shot mode (control bit 7 = 1), the channel sets its flag once and then holds its count at 0 without further expiry.
- R4: The status register at 0x04 is write-one-to-clear. A 0 bit written has no effect on that flag.
- R5: A channel sets its status bit on expiry even when its bit in the enable mask at 0x00 is 0. `irq` is high exactly when some channel has both its status bit and its enable bit set.
- R6: Control bit 1 loads the interval into the counter on the next clock and then reads back as 0. The remaining control fields read back in place: bit 0 enable, bits 6:4 prescale, bit 7 one-shot.
- R7: After the write that clears enable, a running channel still decrements on `STOP_LAT`+1 further clocks (prescale 0) and then freezes.
- R8: A periodic channel loaded with an all-ones interval expires every 2^CW clocks, running through the whole count range.
- R9: Channel n's registers are at 0x10+0x20n (control), 0x14+0x20n (interval) and 0x1C+0x20n (count). Every other address reads 0.
- R10: Prescale field p divides the timer clock by 2^p, for p from 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 32 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered on `rd_en` |
| irq | output | 1 | OR of status AND enable over channels |

## Verification
The bench builds the block with `NCH`=2, `CW`=12 and `STOP_LAT`=2. The 12-bit counter puts an all-ones interval within reach, so the full-range wrap and reload of R8 can be timed in about 4096 clocks. With `STOP_LAT` at 2, the frozen count after a disable is a fixed number that can be predicted exactly. The vector table covers every prescale extreme, a zero interval, and both modes on both channels.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_RUN   = 2'd1,
        CH_DRAIN = 2'd2,
        CH_DONE  = 2'd3
    } ch_state_e;

    localparam int PRE_W = 3;

    localparam logic [31:0] A_IRQ_EN    = 32'h0000_0000;
    localparam logic [31:0] A_IRQ_ST    = 32'h0000_0004;
    localparam logic [31:0] A_CH_BASE   = 32'h0000_0010;
    localparam logic [31:0] A_CH_STRIDE = 32'h0000_0020;
    localparam logic [31:0] A_INTV_REL  = 32'h0000_0004;
    localparam logic [31:0] A_CNT_REL   = 32'h0000_000C;

    localparam int B_EN      = 0;
    localparam int B_RELOAD  = 1;
    localparam int B_PRE_LO  = 4;
    localparam int B_ONESHOT = 7;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int DIV_W = (1 << SEL_W) - 1;

    logic [DIV_W-1:0] acc_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim  = ~({DIV_W{1'b1}} << sel);
        tick = active && !restart && (acc_q == lim);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (restart || !active || tick) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CW       = 32,
    parameter int STOP_LAT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             load,
    input  logic             oneshot,
    input  logic [PRE_W-1:0] sel,
    input  logic [CW-1:0]    interval,
    output logic [CW-1:0]    count,
    output logic             expire
);
    localparam int DW = $clog2(STOP_LAT + 1);

    ch_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] drain_q;
    logic        active, tick, at_zero, drain_done;

    tmr_prescaler #(.SEL_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .restart(load),
        .sel    (sel),
        .tick   (tick)
    );

    // output decode
    always_comb begin
        active     = (state_q == CH_RUN) || (state_q == CH_DRAIN);
        at_zero    = (cnt_q == '0);
        expire     = tick && at_zero;
        drain_done = (drain_q == DW'(STOP_LAT - 1));
        count      = cnt_q;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE:  if (en) state_d = CH_RUN;
            CH_RUN: begin
                if (!en)                       state_d = CH_DRAIN;
                else if (expire && oneshot)    state_d = CH_DONE;
            end
            CH_DRAIN: if (drain_done || (expire && oneshot)) state_d = CH_IDLE;
            CH_DONE: begin
                if (!en)       state_d = CH_IDLE;
                else if (load) state_d = CH_RUN;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                  drain_q <= '0;
        else if (state_q == CH_DRAIN) drain_q <= drain_q + 1'b1;
        else                         drain_q <= '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= interval;
        end else if (expire) begin
            cnt_q <= oneshot ? '0 : interval;
        end else if (tick) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int NCH = 2,
    parameter int CW  = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [31:0]          addr,
    input  logic [31:0]          wdata,
    output logic [31:0]          rdata,
    input  logic [NCH-1:0]       ch_expire,
    input  logic [NCH*CW-1:0]    ch_count,
    output logic [NCH-1:0]       irq_en,
    output logic [NCH-1:0]       irq_st,
    output logic [NCH-1:0]       ctl_en,
    output logic [NCH-1:0]       ctl_load,
    output logic [NCH-1:0]       ctl_oneshot,
    output logic [NCH*PRE_W-1:0] ctl_sel,
    output logic [NCH*CW-1:0]    ctl_intv
);
    logic [NCH-1:0] clr_mask;
    logic [31:0]    rd_part [NCH];
    logic [31:0]    rd_mux;

    assign clr_mask = (wr_en && addr == A_IRQ_ST) ? wdata[NCH-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en <= '0;
            irq_st <= '0;
        end else begin
            if (wr_en && addr == A_IRQ_EN) irq_en <= wdata[NCH-1:0];
            irq_st <= (irq_st & ~clr_mask) | ch_expire;
        end
    end

    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
        localparam logic [31:0] A_CTL = A_CH_BASE + A_CH_STRIDE * 32'(gi);
        localparam logic [31:0] A_IV  = A_CTL + A_INTV_REL;
        localparam logic [31:0] A_CN  = A_CTL + A_CNT_REL;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctl_en[gi]                 <= 1'b0;
                ctl_load[gi]               <= 1'b0;
                ctl_oneshot[gi]            <= 1'b0;
                ctl_sel[gi*PRE_W +: PRE_W] <= '0;
            end else if (wr_en && addr == A_CTL) begin
                ctl_en[gi]                 <= wdata[B_EN];
                ctl_load[gi]               <= wdata[B_RELOAD];
                ctl_oneshot[gi]            <= wdata[B_ONESHOT];
                ctl_sel[gi*PRE_W +: PRE_W] <= wdata[B_PRE_LO +: PRE_W];
            end else begin
                ctl_load[gi]               <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n)                      ctl_intv[gi*CW +: CW] <= '0;
            else if (wr_en && addr == A_IV)  ctl_intv[gi*CW +: CW] <= wdata[CW-1:0];
        end

        always_comb begin
            if (addr == A_CTL)
                rd_part[gi] = {24'b0, ctl_oneshot[gi], ctl_sel[gi*PRE_W +: PRE_W],
                               2'b00, ctl_load[gi], ctl_en[gi]};
            else if (addr == A_IV)
                rd_part[gi] = 32'(ctl_intv[gi*CW +: CW]);
            else if (addr == A_CN)
                rd_part[gi] = 32'(ch_count[gi*CW +: CW]);
            else
                rd_part[gi] = '0;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (addr == A_IRQ_EN) rd_mux = 32'(irq_en);
        if (addr == A_IRQ_ST) rd_mux = 32'(irq_st);
        for (int i = 0; i < NCH; i++) rd_mux = rd_mux | rd_part[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end
endmodule

// File: rtl/tmr_dual_down.sv
module tmr_dual_down
    import tmr_pkg::*;
#(
    parameter int NCH      = 2,
    parameter int CW       = 32,
    parameter int STOP_LAT = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [31:0] addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq
);
    logic [NCH-1:0]       irq_en, irq_st, ctl_en, ctl_load, ctl_oneshot, ch_expire;
    logic [NCH*PRE_W-1:0] ctl_sel;
    logic [NCH*CW-1:0]    ctl_intv, ch_count;

    tmr_regs #(.NCH(NCH), .CW(CW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .ch_expire  (ch_expire),
        .ch_count   (ch_count),
        .irq_en     (irq_en),
        .irq_st     (irq_st),
        .ctl_en     (ctl_en),
        .ctl_load   (ctl_load),
        .ctl_oneshot(ctl_oneshot),
        .ctl_sel    (ctl_sel),
        .ctl_intv   (ctl_intv)
    );

    for (genvar gi = 0; gi < NCH; gi++) begin : g_chan
        tmr_channel #(.CW(CW), .STOP_LAT(STOP_LAT)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (ctl_en[gi]),
            .load    (ctl_load[gi]),
            .oneshot (ctl_oneshot[gi]),
            .sel     (ctl_sel[gi*PRE_W +: PRE_W]),
            .interval(ctl_intv[gi*CW +: CW]),
            .count   (ch_count[gi*CW +: CW]),
            .expire  (ch_expire[gi])
        );
    end

    assign irq = |(irq_en & irq_st);
endmodule

// File: rtl/tmr_dual_chk.sv
module tmr_dual_chk #(
    parameter int NCH = 2,
    parameter int CW  = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wr_en,
    input logic [31:0]    addr,
    input logic           wbit0,
    input logic           irq,
    input logic [NCH-1:0] st,
    input logic           expire0,
    input logic           load0,
    input logic           oneshot0,
    input logic [CW-1:0]  intv0,
    input logic [CW-1:0]  count0
);
    logic clr0;
    assign clr0 = wr_en && (addr == 32'h4) && wbit0;

    p_rst_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (st == '0 && !irq));

    p_load_intv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load0 |=> (count0 == $past(intv0)));

    p_expire_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        expire0 |=> st[0]);

    p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr0 && !expire0) |=> !st[0]);

    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st[0] && !clr0) |=> st[0]);

    p_oneshot_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (expire0 && oneshot0) |=> (count0 == '0));
endmodule

bind tmr_dual_down tmr_dual_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wbit0   (wdata[0]),
    .irq     (irq),
    .st      (irq_st),
    .expire0 (ch_expire[0]),
    .load0   (ctl_load[0]),
    .oneshot0(ctl_oneshot[0]),
    .intv0   (ctl_intv[CW-1:0]),
    .count0  (ch_count[CW-1:0])
);

// File: tb/sim_tmr_dual_down.sv
`timescale 1ns/1ps
module sim_tmr_dual_down;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    tmr_dual_down #(.NCH(2), .CW(12), .STOP_LAT(2)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    typedef struct packed {
        logic        ch;
        logic        os;
        logic [2:0]  sel;
        logic [31:0] intv;
        logic [31:0] n1;
    } vec_t;

    // n1 = 1 + (intv+1) << sel  (R2, R10)
    localparam vec_t VECS [7] = '{
        '{1'b0, 1'b0, 3'd0, 32'd5,    32'd7},
        '{1'b0, 1'b0, 3'd2, 32'd3,    32'd17},
        '{1'b1, 1'b0, 3'd1, 32'd10,   32'd23},
        '{1'b0, 1'b0, 3'd0, 32'd0,    32'd2},
        '{1'b1, 1'b1, 3'd7, 32'd2,    32'd385},
        '{1'b0, 1'b1, 3'd3, 32'd6,    32'd57},
        '{1'b1, 1'b0, 3'd0, 32'd4095, 32'd4097}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic wait_irq(input int limit, output int n);
        n = 0;
        while (!irq && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(irq == 1'b0, "R1 irq", 32'(irq), 0);
        rd(32'h00, v); check(v == 0, "R1 irq_en", v, 0);
        rd(32'h04, v); check(v == 0, "R1 irq_st", v, 0);
        rd(32'h10, v); check(v == 0, "R1 ctl0", v, 0);
        rd(32'h3C, v); check(v == 0, "R1 cnt1", v, 0);

        // R6 reload self-clear and field readback
        wr(32'h14, 32'd50);
        wr(32'h10, 32'hD2);
        @(negedge clk);
        rd(32'h10, v); check(v == 32'hD0, "R6 ctl readback", v, 32'hD0);
        rd(32'h1C, v); check(v == 50, "R6 count loaded", v, 50);
        wr(32'h10, 32'h0);

        // R9 address map
        wr(32'h34, 32'h5A5);
        rd(32'h34, v); check(v == 32'h5A5, "R9 intv1", v, 32'h5A5);
        rd(32'h08, v); check(v == 0, "R9 unmapped 08", v, 0);
        rd(32'h18, v); check(v == 0, "R9 unmapped 18", v, 0);
        rd(32'h50, v); check(v == 0, "R9 unmapped 50", v, 0);
        rd(32'h1010, v); check(v == 0, "R9 unmapped 1010", v, 0);

        // R7 disable latency
        wr(32'h14, 32'd100);
        wr(32'h10, 32'h3);
        wr(32'h10, 32'h0);
        repeat (10) @(negedge clk);
        rd(32'h1C, v); check(v == 97, "R7 drain back-to-back", v, 97);
        repeat (3) @(negedge clk);
        rd(32'h1C, v); check(v == 97, "R7 frozen", v, 97);
        wr(32'h10, 32'h3);
        repeat (4) @(negedge clk);
        wr(32'h10, 32'h0);
        repeat (10) @(negedge clk);
        rd(32'h1C, v); check(v == 93, "R7 drain after gap", v, 93);

        // R5 status sets while masked, irq gating; R4 W1C
        wr(32'h04, 32'h3);
        wr(32'h00, 32'h0);
        wr(32'h14, 32'd3);
        wr(32'h10, 32'h3);
        repeat (12) @(negedge clk);
        check(irq == 1'b0, "R5 masked irq", 32'(irq), 0);
        rd(32'h04, v); check(v[0] == 1'b1, "R5 status while masked", 32'(v[0]), 1);
        wr(32'h00, 32'h1);
        check(irq == 1'b1, "R5 irq after unmask", 32'(irq), 1);
        wr(32'h10, 32'h0);
        repeat (10) @(negedge clk);
        wr(32'h04, 32'h0);
        rd(32'h04, v); check(v[0] == 1'b1, "R4 zero write keeps", 32'(v[0]), 1);
        wr(32'h04, 32'h1);
        rd(32'h04, v); check(v[0] == 1'b0, "R4 one write clears", 32'(v[0]), 0);
        check(irq == 1'b0, "R4 irq after clear", 32'(irq), 0);

        // Table walk: R2 R3 R8 R10
        foreach (VECS[i]) begin
            logic [31:0] base;
            int per;
            base = 32'h10 + 32'h20 * 32'(VECS[i].ch);
            per  = int'(VECS[i].n1) - 1;
            wr(32'h04, 32'h3);
            wr(32'h00, 32'(1) << VECS[i].ch);
            wr(base + 32'h4, VECS[i].intv);
            wr(base, {24'b0, VECS[i].os, VECS[i].sel, 4'b0011});
            wait_irq(2 * int'(VECS[i].n1) + 20, n);
            check(n == int'(VECS[i].n1), "R2/R10 first expiry", 32'(n), VECS[i].n1);
            wr(32'h04, 32'h3);
            if (VECS[i].os) begin
                wait_irq(2 * per + 10, n);
                check(n == 2 * per + 10, "R3 no second expiry", 32'(n), 32'(2 * per + 10));
                rd(base + 32'hC, v); check(v == 0, "R3 count held at zero", v, 0);
            end else begin
                wait_irq(2 * per + 10, n);
                if (VECS[i].intv == 32'd4095)
                    check(n == per - 1, "R8 full-range period", 32'(n), 32'(per - 1));
                else
                    check(n == per - 1, "R2 periodic repeat", 32'(n), 32'(per - 1));
            end
            wr(base, 32'h0);
            repeat (8) @(negedge clk);
            wr(32'h04, 32'h3);
        end

        finish_run();
    end
endmodule